// File: doc/BRIEF.md
# Arcade Raster Timing Generator

This block produces the horizontal and vertical timing of a fixed-resolution raster display. It is stepped by a pixel-clock enable in the system clock domain. A pixel counter runs across each line and a line counter runs down each frame. Both counters begin at the end of the sync pulse, so a line opens with its left border and a frame opens with its top border. From these counters the block decodes active-low horizontal sync, vertical sync and a composite blank. It also gives beam X/Y coordinates relative to the top-left of the visible window, and a one-cycle start-of-frame strobe.

A one-bit screen-mode setting selects between two frame types. Mode 0 is the normal 424-line frame. Mode 1 is a 512-line frame in which vertical blanking is deliberately misplaced: the visible window overlaps the vertical sync pulse. The horizontal timing is the same in both modes. A frame-buffer auto-erase request normally follows the start-of-frame strobe, and it is held off while mode 1 is in force. A mode write is stored at once but only takes effect when the current frame ends.

At the defaults, with a 16 MHz pixel enable, the normal frame gives about 57.5 frames per second.

Top module: `raster_timer`

## Requirements
- R1: The pixel counter runs 0..655 and wraps to 0 after 655. Pixels 0..68 are the left border, 69..564 are active, 565..607 are the right border, and hsync_n is low exactly on pixels 608..655.
- R2: The line counter advances only when the pixel counter wraps. In mode 0 it runs 0..423, and vsync_n is low exactly on lines 420..423.
- R3: blank_n is high only when the pixel is in 69..564 and the line is in the active range. In mode 0 the active range is lines 25..408, so blank_n is low whenever vsync_n is low.
- R4: beam_x equals pixel minus 69 while the pixel is in 69..564, and is 0 otherwise. beam_y equals line minus 25 while the line is in the active range, and is 0 otherwise.
- R5: In mode 1 the horizontal timing of R1 is unchanged.
- R6: In mode 1 the frame is 512 lines (0..511). vsync_n is low on lines 508..511, and the active line range is 25..511, so blank_n is high during part of vertical sync.
- R7: sof is high for exactly one system clock, on the cycle where pix_en is high at pixel 0 of line 0.
- R8: erase_req equals sof while mode 0 is in force and is never high while mode 1 is in force.
- R9: While pix_en is low, neither counter moves, so sync, blank and beam outputs hold their values.
- R10: A write with mode_we high stores mode_wdata (1 selects mode 1). The new mode takes effect only when the last pixel of the last line of the current frame is passed with pix_en high. The current frame keeps its old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; counters to 0, mode 0 |
| pix_en | input | 1 | Pixel-clock enable; one pixel per high cycle |
| mode_we | input | 1 | Screen-mode register write strobe |
| mode_wdata | input | 1 | Screen-mode value: 0 normal, 1 512-line |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| blank_n | output | 1 | Composite blank, high only in the visible window |
| beam_x | output | XW | Pixel within the active line, 0 outside it |
| beam_y | output | YW | Line within the active frame, 0 outside it |
| sof | output | 1 | Start-of-frame strobe |
| erase_req | output | 1 | Frame-buffer auto-erase request, mode 0 only |

## Verification
The embedded properties assume that the geometry parameters describe a consistent raster: every segment is non-empty, and the 512-line sync start lies inside the longer frame past its top border. They place no limit on how pix_en is spaced or on when mode writes arrive, including a write on the very cycle a frame ends. The main instance is built with a scaled-down geometry so that many frames in both modes fit the run. Its stimulus mixes random enable patterns and occasional mode writes with directed stretches of held enable and of mid-frame mode changes. A second instance at the default geometry is run far enough to check the literal pixel and line positions.

// File: rtl/raster_pkg.sv
package raster_pkg;

    typedef enum logic {
        SCAN_NORMAL = 1'b0,
        SCAN_TALL   = 1'b1
    } scan_mode_e;

    // Decoded state of one raster axis
    typedef struct packed {
        logic active;  // inside the visible window on this axis
        logic sync;    // inside the sync pulse on this axis
        logic last;    // counter is about to wrap on this step
    } axis_flags_t;

    typedef struct packed {
        scan_mode_e mode;  // mode used by the frame in progress
        logic       pend;  // value that the next frame will use
    } mode_state_t;

endpackage

// File: rtl/raster_hctr.sv
module raster_hctr
    import raster_pkg::*;
#(
    parameter int LBORD = 69,
    parameter int ACT   = 496,
    parameter int RBORD = 43,
    parameter int SYNC  = 48,
    parameter int W     = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pix_en,
    output logic [W-1:0] pos,
    output axis_flags_t  flags
);

    localparam int TOTAL = LBORD + ACT + RBORD + SYNC;
    localparam logic [W-1:0] LAST    = W'(TOTAL - 1);
    localparam logic [W-1:0] ACT_LO  = W'(LBORD);
    localparam logic [W-1:0] ACT_HI  = W'(LBORD + ACT - 1);
    localparam logic [W-1:0] SYNC_LO = W'(LBORD + ACT + RBORD);

    typedef struct packed {
        logic [W-1:0] pos;
    } hstate_t;

    hstate_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pix_en) begin
            st_d.pos = (st_q.pos == LAST) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pos          = st_q.pos;
    assign flags.active = (st_q.pos >= ACT_LO) && (st_q.pos <= ACT_HI);
    assign flags.sync   = (st_q.pos >= SYNC_LO);
    assign flags.last   = pix_en && (st_q.pos == LAST);

    assert_h_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos <= LAST);

    assert_h_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && st_q.pos == LAST) |=> (st_q.pos == '0));

    assert_h_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> $stable(st_q.pos));

endmodule

// File: rtl/raster_vctr.sv
module raster_vctr
    import raster_pkg::*;
#(
    parameter int TBORD      = 25,
    parameter int ACT        = 384,
    parameter int BBORD      = 11,
    parameter int SYNC       = 4,
    parameter int TALL_LINES = 512,
    parameter int TALL_SYNC  = 508,
    parameter int W          = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  scan_mode_e   mode,
    output logic [W-1:0] pos,
    output axis_flags_t  flags
);

    localparam int NORM_TOTAL = TBORD + ACT + BBORD + SYNC;
    localparam logic [W-1:0] NORM_LAST    = W'(NORM_TOTAL - 1);
    localparam logic [W-1:0] TALL_LAST    = W'(TALL_LINES - 1);
    localparam logic [W-1:0] ACT_LO       = W'(TBORD);
    localparam logic [W-1:0] NORM_ACT_HI  = W'(TBORD + ACT - 1);
    localparam logic [W-1:0] NORM_SYNC_LO = W'(TBORD + ACT + BBORD);
    localparam logic [W-1:0] TALL_SYNC_LO = W'(TALL_SYNC);

    typedef struct packed {
        logic [W-1:0] pos;
    } vstate_t;

    vstate_t      st_d, st_q;
    logic [W-1:0] last_line;

    always_comb begin
        last_line = (mode == SCAN_TALL) ? TALL_LAST : NORM_LAST;
        st_d      = st_q;
        if (step) begin
            st_d.pos = (st_q.pos == last_line) ? '0 : st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (mode == SCAN_TALL) begin
            // Misaligned window: visible all the way through vertical sync
            flags.active = (st_q.pos >= ACT_LO);
            flags.sync   = (st_q.pos >= TALL_SYNC_LO);
        end else begin
            flags.active = (st_q.pos >= ACT_LO) && (st_q.pos <= NORM_ACT_HI);
            flags.sync   = (st_q.pos >= NORM_SYNC_LO);
        end
        flags.last = step && (st_q.pos == last_line);
    end

    assign pos = st_q.pos;

    assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.pos));

    assert_v_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SCAN_NORMAL) |-> (st_q.pos <= NORM_LAST));

    assert_v_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SCAN_TALL) |-> (st_q.pos <= TALL_LAST));

endmodule

// File: rtl/raster_timer.sv
module raster_timer
    import raster_pkg::*;
#(
    parameter int H_LBORD   = 69,
    parameter int H_ACT     = 496,
    parameter int H_RBORD   = 43,
    parameter int H_SYNC    = 48,
    parameter int V_TBORD   = 25,
    parameter int V_ACT     = 384,
    parameter int V_BBORD   = 11,
    parameter int V_SYNC    = 4,
    parameter int TALL_LINES = 512,
    parameter int TALL_SYNC  = 508,
    localparam int HTOTAL = H_LBORD + H_ACT + H_RBORD + H_SYNC,
    localparam int VNORM  = V_TBORD + V_ACT + V_BBORD + V_SYNC,
    localparam int VMAX   = (TALL_LINES > VNORM) ? TALL_LINES : VNORM,
    localparam int HW     = $clog2(HTOTAL),
    localparam int VW     = $clog2(VMAX),
    localparam int XW     = $clog2(H_ACT),
    localparam int YSPAN  = ((TALL_LINES - V_TBORD) > V_ACT) ? (TALL_LINES - V_TBORD) : V_ACT,
    localparam int YW     = $clog2(YSPAN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    input  logic          mode_we,
    input  logic          mode_wdata,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          blank_n,
    output logic [XW-1:0] beam_x,
    output logic [YW-1:0] beam_y,
    output logic          sof,
    output logic          erase_req
);

    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    axis_flags_t   h_flags, v_flags;
    mode_state_t   ms_d, ms_q;

    raster_hctr #(
        .LBORD(H_LBORD), .ACT(H_ACT), .RBORD(H_RBORD), .SYNC(H_SYNC), .W(HW)
    ) hctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pix_en(pix_en),
        .pos   (h_pos),
        .flags (h_flags)
    );

    raster_vctr #(
        .TBORD(V_TBORD), .ACT(V_ACT), .BBORD(V_BBORD), .SYNC(V_SYNC),
        .TALL_LINES(TALL_LINES), .TALL_SYNC(TALL_SYNC), .W(VW)
    ) vctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .step (h_flags.last),
        .mode (ms_q.mode),
        .pos  (v_pos),
        .flags(v_flags)
    );

    // Mode register: store at once, apply at frame end
    always_comb begin
        ms_d = ms_q;
        if (v_flags.last) ms_d.mode = scan_mode_e'(ms_q.pend);
        if (mode_we)      ms_d.pend = mode_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ms_q <= '{mode: SCAN_NORMAL, pend: 1'b0};
        else        ms_q <= ms_d;
    end

    assign hsync_n   = ~h_flags.sync;
    assign vsync_n   = ~v_flags.sync;
    assign blank_n   = h_flags.active & v_flags.active;
    assign beam_x    = h_flags.active ? XW'(h_pos - HW'(H_LBORD)) : '0;
    assign beam_y    = v_flags.active ? YW'(v_pos - VW'(V_TBORD)) : '0;
    assign sof       = pix_en && (h_pos == '0) && (v_pos == '0);
    assign erase_req = sof && (ms_q.mode == SCAN_NORMAL);

    assert_mode_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !v_flags.last |=> $stable(ms_q.mode));

    assert_sof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    assert_sync_blanked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync_n && ms_q.mode == SCAN_NORMAL) |-> !blank_n);

    assert_erase_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> (sof && !blank_n && !hsync_n == 1'b0));

endmodule

// File: tb/raster_timer_tb_top.sv
module raster_timer_tb_top;

    // Scaled geometry for the main instance
    localparam int LB = 5, HA = 12, RB = 3, HS = 4;
    localparam int TB = 3, VA = 6, BB = 2, VS = 2;
    localparam int TL = 16, TSA = 12;
    localparam int HT = LB + HA + RB + HS;
    localparam int VT = TB + VA + BB + VS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0, mode_we = 1'b0, mode_wdata = 1'b0;
    logic hsync_n, vsync_n, blank_n, sof, erase_req;
    logic [3:0] beam_x, beam_y;

    logic def_pix_en = 1'b0;
    logic d_hsync_n, d_vsync_n, d_blank_n, d_sof, d_erase;
    logic [8:0] d_beam_x, d_beam_y;

    int checks = 0, fails = 0, cyc_cnt = 0;
    bit done = 1'b0;

    int hm = 0, vm = 0;
    bit mode_m = 1'b0, pend_m = 1'b0;

    always #2 clk = ~clk;

    raster_timer #(
        .H_LBORD(LB), .H_ACT(HA), .H_RBORD(RB), .H_SYNC(HS),
        .V_TBORD(TB), .V_ACT(VA), .V_BBORD(BB), .V_SYNC(VS),
        .TALL_LINES(TL), .TALL_SYNC(TSA)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .blank_n(blank_n), .beam_x(beam_x), .beam_y(beam_y), .sof(sof),
        .erase_req(erase_req)
    );

    raster_timer dut_def_i (
        .clk(clk), .rst_n(rst_n), .pix_en(def_pix_en), .mode_we(1'b0),
        .mode_wdata(1'b0), .hsync_n(d_hsync_n), .vsync_n(d_vsync_n),
        .blank_n(d_blank_n), .beam_x(d_beam_x), .beam_y(d_beam_y), .sof(d_sof),
        .erase_req(d_erase)
    );

    // Reference raster state, stepped from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            hm = 0; vm = 0; mode_m = 1'b0; pend_m = 1'b0;
        end else begin
            if (pix_en) begin
                automatic bit wrap_h = (hm == HT - 1);
                automatic int last_v = mode_m ? TL - 1 : VT - 1;
                automatic bit fend = wrap_h && (vm == last_v);
                hm = wrap_h ? 0 : hm + 1;
                if (wrap_h) vm = (vm == last_v) ? 0 : vm + 1;
                if (fend) mode_m = pend_m;
            end
            if (mode_we) pend_m = mode_wdata;
        end
    end

    function automatic bit e_hact(int h);
        return (h >= LB) && (h < LB + HA);
    endfunction
    function automatic bit e_vact(int v, bit tall);
        return tall ? (v >= TB) : ((v >= TB) && (v < TB + VA));
    endfunction
    function automatic bit e_vsync_n(int v, bit tall);
        return tall ? !(v >= TSA) : !(v >= TB + VA + BB);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        automatic bit ha = e_hact(hm);
        automatic bit va = e_vact(vm, mode_m);
        automatic bit org = pix_en && hm == 0 && vm == 0;
        if (mode_m) chk("R5 hsync_n in tall mode", hsync_n, !(hm >= LB + HA + RB));
        else        chk("R1 hsync_n", hsync_n, !(hm >= LB + HA + RB));
        if (pend_m != mode_m) chk("R10 vsync_n before frame end", vsync_n, e_vsync_n(vm, mode_m));
        else if (mode_m)      chk("R6 vsync_n tall", vsync_n, e_vsync_n(vm, mode_m));
        else                  chk("R2 vsync_n", vsync_n, e_vsync_n(vm, mode_m));
        if (mode_m) chk("R6 blank_n tall", blank_n, ha && va);
        else        chk("R3 blank_n", blank_n, ha && va);
        chk("R4 beam_x", beam_x, ha ? hm - LB : 0);
        chk("R4 beam_y", beam_y, va ? vm - TB : 0);
        chk("R7 sof", sof, org);
        chk("R8 erase_req", erase_req, org && !mode_m);
    endtask

    task automatic cyc(input bit pe, input bit we, input bit wd);
        @(negedge clk);
        compare();
        pix_en = pe; mode_we = we; mode_wdata = wd;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc_cnt);
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // Reset state
        chk("R1 hsync_n at reset", hsync_n, 1);
        chk("R2 vsync_n at reset", vsync_n, 1);
        chk("R3 blank_n at reset", blank_n, 0);
        chk("R7 sof at reset", sof, 0);
        chk("R8 erase_req at reset", erase_req, 0);
        rst_n = 1'b1;

        // Two normal frames with steady enable
        for (int i = 0; i < 2 * HT * VT; i++) cyc(1'b1, 1'b0, 1'b0);

        // R9: enable held low, outputs must freeze
        for (int i = 0; i < 7; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0);
        begin
            automatic logic hs0, vs0, bl0;
            automatic logic [3:0] bx0, by0;
            @(negedge clk);
            hs0 = hsync_n; vs0 = vsync_n; bl0 = blank_n; bx0 = beam_x; by0 = beam_y;
            for (int i = 0; i < 25; i++) cyc(1'b0, 1'b0, 1'b0);
            @(negedge clk);
            chk("R9 hsync_n held", hsync_n, hs0);
            chk("R9 vsync_n held", vsync_n, vs0);
            chk("R9 blank_n held", blank_n, bl0);
            chk("R9 beam_x held", beam_x, bx0);
            chk("R9 beam_y held", beam_y, by0);
        end

        // R10: mid-frame switch to tall mode, then run two tall frames
        for (int i = 0; i < 40; i++) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, 1'b1);
        begin
            automatic int overlap = 0;
            automatic int erases = 0;
            for (int i = 0; i < HT * VT + 2 * HT * TL; i++) begin
                cyc(1'b1, 1'b0, 1'b0);
                if (mode_m && !vsync_n && blank_n) overlap++;
                if (mode_m && erase_req) erases++;
            end
            chk("R6 visible during vertical sync (cycles>0)", overlap > 0, 1);
            chk("R8 no erase in tall mode", erases, 0);
        end

        // Back to normal, then random enable and mode writes
        cyc(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 9000; i++)
            cyc(($urandom % 10) < 7, ($urandom % 300) == 0, $urandom % 2);
        // Write on the exact frame-end cycle
        while (!(hm == HT - 1 && vm == (mode_m ? TL - 1 : VT - 1))) cyc(1'b1, 1'b0, 1'b0);
        cyc(1'b1, 1'b1, ~mode_m);
        for (int i = 0; i < 2 * HT * TL; i++) cyc(1'b1, 1'b0, 1'b0);
        @(negedge clk);
        compare();
        pix_en = 1'b0;

        // Default geometry: literal positions
        def_pix_en = 1'b1;
        begin
            automatic int first_hs = -1, hs_low = 0, first_bl = -1, vs_low = 0;
            automatic int bx_at = -1, by_at = -1;
            for (int k = 1; k <= 25 * 656 + 80; k++) begin
                @(negedge clk);
                if (k <= 656 && !d_hsync_n) hs_low++;
                if (first_hs < 0 && !d_hsync_n) first_hs = k;
                if (!d_vsync_n) vs_low++;
                if (first_bl < 0 && d_blank_n) begin
                    first_bl = k; bx_at = d_beam_x; by_at = d_beam_y;
                end
            end
            chk("R1 default first hsync pixel", first_hs, 608);
            chk("R1 default hsync width", hs_low, 48);
            chk("R3 default first visible cycle", first_bl, 25 * 656 + 69);
            chk("R4 default beam_x at window corner", bx_at, 0);
            chk("R4 default beam_y at window corner", by_at, 0);
            chk("R2 default no vsync in first lines", vs_low, 0);
        end
        def_pix_en = 1'b0;
        finish_run();
    end

endmodule